// File: doc/BRIEF.md
# Indexed Register Access Unit with Post-Increment

This unit sits between a small 8-bit sequencer and a 256-byte register and scratch file. It gives the sequencer one read port and one write port per cycle. Most addresses go straight to the file. A few addresses are decoded inside the unit. These cover two 16-bit index registers, a pair of indirect windows that step through the file, two constant sources, a write sink and a one-hot conversion register.

A read of the source window returns the file byte at a fixed base plus the source index. The source index then advances by one. A write to the destination window stores at the base plus the destination index, and the destination index then advances by one. Table walks and block copies therefore need no explicit pointer arithmetic. The conversion register turns a 3-bit number written in the upper nibble into a byte with only that bit set.

Top module: `seq_indirect_port`

## Requirements
- R1: After reset both index registers read 0x0000, the conversion register reads 0x01, and `rd_valid` is low.
- R2: The source index is readable and writable directly as two bytes: low byte at 0xE2 and high byte at 0xE3. The destination index is the same at 0xE4 (low) and 0xE5 (high).
- R3: A read of 0xEC returns the file byte at `FILE_BASE + src_index[7:0]` (mod 256). The source index is one higher from the next cycle on.
- R4: A write to 0xED stores `wr_data` in the file at `FILE_BASE + dst_index[7:0]` (mod 256). The destination index is one higher from the next cycle on.
- R5: Only the low 8 bits of an index select the file byte. Both indexes wrap from 0xFFFF to 0x0000.
- R6: A read of 0xE8 returns 0xFF and a read of 0xEA returns 0x00. Writes to 0xE8, 0xEA and 0xEC change no state, including the file bytes at those addresses.
- R7: A write to 0xF0 stores `wr_data[6:4]` and ignores bit 7 and the low nibble. Every later read of 0xF0 returns a byte with only that bit set (write 0x60, read 0x40). Reads do not clear it.
- R8: If a direct write to a source index byte lands in the same cycle as a read of 0xEC, the written byte takes effect. The increment is dropped and the other byte keeps its value.
- R9: `rd_data` and a high `rd_valid` appear one cycle after `rd_en`. All addresses not listed above read and write the file directly.
- R10: A read and a write of the same file address in one cycle return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request this cycle |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read result, one cycle after the request |
| rd_valid | output | 1 | High in the cycle that `rd_data` holds a result |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |

## Verification
The bench builds the unit with `FILE_BASE` set to 0x20 rather than the default 0x00. With that base, window addresses differ from the raw index values. An index low byte above 0xDF then wraps the file address through 0xFF back to the bottom of the file. The same base lets the destination window reach raw file bytes behind the decoded constant and sink addresses. This shows that direct writes there leave the file untouched. Index values near 0xFFFF and same-cycle collisions on the source index are driven explicitly.

// File: rtl/seq_indirect_pkg.sv
package seq_indirect_pkg;

    // Address class produced by the decoder.
    typedef enum logic [3:0] {
        SEL_FILE,
        SEL_SRC_LO,
        SEL_SRC_HI,
        SEL_DST_LO,
        SEL_DST_HI,
        SEL_ONES,
        SEL_ZEROS,
        SEL_SRC_WIN,
        SEL_DST_WIN,
        SEL_ONEHOT
    } addr_sel_e;

    localparam logic [7:0] DEF_SRC_LO  = 8'hE2;
    localparam logic [7:0] DEF_DST_LO  = 8'hE4;
    localparam logic [7:0] DEF_ONES    = 8'hE8;
    localparam logic [7:0] DEF_ZEROS   = 8'hEA;
    localparam logic [7:0] DEF_SRC_WIN = 8'hEC;
    localparam logic [7:0] DEF_DST_WIN = 8'hED;
    localparam logic [7:0] DEF_ONEHOT  = 8'hF0;

endpackage

// File: rtl/seq_addr_decode.sv
module seq_addr_decode
    import seq_indirect_pkg::*;
#(
    parameter int unsigned    ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] SRC_LO   = ADDR_W'(DEF_SRC_LO),
    parameter logic [ADDR_W-1:0] DST_LO   = ADDR_W'(DEF_DST_LO),
    parameter logic [ADDR_W-1:0] ONES     = ADDR_W'(DEF_ONES),
    parameter logic [ADDR_W-1:0] ZEROS    = ADDR_W'(DEF_ZEROS),
    parameter logic [ADDR_W-1:0] SRC_WIN  = ADDR_W'(DEF_SRC_WIN),
    parameter logic [ADDR_W-1:0] DST_WIN  = ADDR_W'(DEF_DST_WIN),
    parameter logic [ADDR_W-1:0] ONEHOT   = ADDR_W'(DEF_ONEHOT)
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_sel_e         sel
);

    localparam logic [ADDR_W-1:0] SRC_HI = SRC_LO + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] DST_HI = DST_LO + ADDR_W'(1);

    always_comb begin
        if      (addr == SRC_LO)  sel = SEL_SRC_LO;
        else if (addr == SRC_HI)  sel = SEL_SRC_HI;
        else if (addr == DST_LO)  sel = SEL_DST_LO;
        else if (addr == DST_HI)  sel = SEL_DST_HI;
        else if (addr == ONES)    sel = SEL_ONES;
        else if (addr == ZEROS)   sel = SEL_ZEROS;
        else if (addr == SRC_WIN) sel = SEL_SRC_WIN;
        else if (addr == DST_WIN) sel = SEL_DST_WIN;
        else if (addr == ONEHOT)  sel = SEL_ONEHOT;
        else                      sel = SEL_FILE;
    end

endmodule

// File: rtl/seq_scratch_file.sv
module seq_scratch_file #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Asynchronous read sees the contents before this cycle's write (R10).
    assign rdata = mem_q[raddr];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/seq_indirect_port.sv
module seq_indirect_port
    import seq_indirect_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 8,
    parameter int unsigned       DATA_W    = 8,
    parameter logic [ADDR_W-1:0] FILE_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int unsigned IDX_W = 2 * DATA_W;
    localparam int unsigned OH_W  = $clog2(DATA_W);
    localparam int unsigned OH_LO = DATA_W / 2;

    typedef struct packed {
        logic [IDX_W-1:0]  src_idx;
        logic [IDX_W-1:0]  dst_idx;
        logic [OH_W-1:0]   oh_sel;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } state_t;

    state_t state_d, state_q;

    addr_sel_e         rd_sel, wr_sel;
    logic [ADDR_W-1:0] file_raddr, file_waddr;
    logic [DATA_W-1:0] file_rdata;
    logic              file_we;
    logic              src_wr_hit;

    seq_addr_decode #(.ADDR_W(ADDR_W)) i_rd_dec (.addr(rd_addr), .sel(rd_sel));
    seq_addr_decode #(.ADDR_W(ADDR_W)) i_wr_dec (.addr(wr_addr), .sel(wr_sel));

    always_comb begin
        file_raddr = (rd_sel == SEL_SRC_WIN)
                   ? FILE_BASE + state_q.src_idx[ADDR_W-1:0] : rd_addr;
        file_waddr = (wr_sel == SEL_DST_WIN)
                   ? FILE_BASE + state_q.dst_idx[ADDR_W-1:0] : wr_addr;
        file_we    = wr_en && (wr_sel == SEL_FILE || wr_sel == SEL_DST_WIN);
    end

    seq_scratch_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_file (
        .clk   (clk),
        .raddr (file_raddr),
        .rdata (file_rdata),
        .we    (file_we),
        .waddr (file_waddr),
        .wdata (wr_data)
    );

    always_comb begin
        state_d        = state_q;
        state_d.rvalid = rd_en;
        src_wr_hit     = wr_en && (wr_sel == SEL_SRC_LO || wr_sel == SEL_SRC_HI);

        if (rd_en) begin
            unique case (rd_sel)
                SEL_FILE,
                SEL_SRC_WIN: state_d.rdata = file_rdata;
                SEL_SRC_LO:  state_d.rdata = state_q.src_idx[DATA_W-1:0];
                SEL_SRC_HI:  state_d.rdata = state_q.src_idx[IDX_W-1:DATA_W];
                SEL_DST_LO:  state_d.rdata = state_q.dst_idx[DATA_W-1:0];
                SEL_DST_HI:  state_d.rdata = state_q.dst_idx[IDX_W-1:DATA_W];
                SEL_ONES:    state_d.rdata = '1;
                SEL_ONEHOT:  state_d.rdata = DATA_W'(1) << state_q.oh_sel;
                default:     state_d.rdata = '0;
            endcase
        end

        // Post-increment of the source index unless a direct write wins (R8).
        if (rd_en && rd_sel == SEL_SRC_WIN && !src_wr_hit) begin
            state_d.src_idx = state_q.src_idx + IDX_W'(1);
        end

        if (wr_en) begin
            unique case (wr_sel)
                SEL_SRC_LO:  state_d.src_idx[DATA_W-1:0]     = wr_data;
                SEL_SRC_HI:  state_d.src_idx[IDX_W-1:DATA_W] = wr_data;
                SEL_DST_LO:  state_d.dst_idx[DATA_W-1:0]     = wr_data;
                SEL_DST_HI:  state_d.dst_idx[IDX_W-1:DATA_W] = wr_data;
                SEL_DST_WIN: state_d.dst_idx = state_q.dst_idx + IDX_W'(1);
                SEL_ONEHOT:  state_d.oh_sel  = wr_data[OH_LO +: OH_W];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data  = state_q.rdata;
    assign rd_valid = state_q.rvalid;

    // R3: source window read advances the index by one
    a_r3_src_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_SRC_WIN && !(wr_en &&
         (wr_sel == SEL_SRC_LO || wr_sel == SEL_SRC_HI)))
        |=> state_q.src_idx == $past(state_q.src_idx) + IDX_W'(1));

    // R4: destination window write advances the index by one
    a_r4_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DST_WIN)
        |=> state_q.dst_idx == $past(state_q.dst_idx) + IDX_W'(1));

    // R6: constant source reads
    a_r6_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_ONES) |=> rd_data == '1);

    // R7: conversion register always yields exactly one set bit
    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_ONEHOT) |=> $countones(rd_data) == 1);

    // R8: direct low-byte write wins over the increment
    a_r8_direct_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_SRC_WIN && wr_en && wr_sel == SEL_SRC_LO)
        |=> state_q.src_idx[DATA_W-1:0] == $past(wr_data)
            && $stable(state_q.src_idx[IDX_W-1:DATA_W]));

    // R9: result strobe follows the request by one cycle
    a_r9_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

endmodule

// File: tb/test_seq_indirect_port.sv
`timescale 1ns/1ps
module test_seq_indirect_port;

    localparam logic [7:0] BASE = 8'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] rd_addr = '0, wr_addr = '0, wr_data = '0;
    logic [7:0] rd_data;
    logic       rd_valid;

    always #4 clk = ~clk;

    seq_indirect_port #(.FILE_BASE(BASE)) i_seq_indirect_port (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data));

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0, errors = 0;
    bit          done = 1'b0;
    logic [7:0]  mfile [256];
    logic [15:0] msrc = '0, mdst = '0;
    logic [2:0]  moh = '0;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Driver: one cycle of access, expected read pushed into the scoreboard.
    task automatic op(bit re, logic [7:0] ra, bit we, logic [7:0] wa,
                      logic [7:0] wd, string tag);
        exp_t e;
        rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
        if (re) begin
            case (ra)
                8'hE2:   e.val = msrc[7:0];
                8'hE3:   e.val = msrc[15:8];
                8'hE4:   e.val = mdst[7:0];
                8'hE5:   e.val = mdst[15:8];
                8'hE8:   e.val = 8'hFF;
                8'hEA:   e.val = 8'h00;
                8'hEC:   e.val = mfile[8'(BASE + msrc[7:0])];
                8'hED:   e.val = 8'h00;
                8'hF0:   e.val = 8'(1) << moh;
                default: e.val = mfile[ra];
            endcase
            e.tag = tag;
            sb.push_back(e);
        end
        if (re && ra == 8'hEC && !(we && (wa == 8'hE2 || wa == 8'hE3)))
            msrc = msrc + 16'd1;
        if (we) begin
            case (wa)
                8'hE2:   msrc[7:0]  = wd;
                8'hE3:   msrc[15:8] = wd;
                8'hE4:   mdst[7:0]  = wd;
                8'hE5:   mdst[15:8] = wd;
                8'hE8, 8'hEA, 8'hEC: ;
                8'hED: begin
                    mfile[8'(BASE + mdst[7:0])] = wd;
                    mdst = mdst + 16'd1;
                end
                8'hF0:   moh = wd[6:4];
                default: mfile[wa] = wd;
            endcase
        end
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, string tag);
        op(1'b1, a, 1'b0, 8'h00, 8'h00, tag);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
        op(1'b0, 8'h00, 1'b1, a, d, tag);
    endtask

    // Monitor: compare results in order as they appear.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R9: actual unexpected rd_valid data %h, expected no result", rd_data);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rd_data !== e.val) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", e.tag, rd_data, e.val);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog: actual run not complete, expected complete");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual rd_valid %b expected 0", rd_valid);
        end
        // R1 reset values
        rd(8'hE2, "R1"); rd(8'hE3, "R1"); rd(8'hE4, "R1"); rd(8'hE5, "R1");
        rd(8'hF0, "R1");
        // R9 ordinary file access
        for (int i = 0; i < 8; i++) wr(8'(8'h20 + i), 8'(8'hA0 + 3 * i), "R9");
        for (int i = 0; i < 8; i++) rd(8'(8'h20 + i), "R9");
        // R10 same-cycle read and write of one file byte
        op(1'b1, 8'h21, 1'b1, 8'h21, 8'h5C, "R10");
        rd(8'h21, "R10");
        // R2 direct index access, R3 source window walk
        wr(8'hE2, 8'h00, "R2"); wr(8'hE3, 8'h00, "R2");
        for (int i = 0; i < 4; i++) rd(8'hEC, "R3");
        rd(8'hE2, "R3"); rd(8'hE3, "R3");
        // R4 destination window
        wr(8'hE4, 8'h40, "R2"); wr(8'hE5, 8'h7B, "R2");
        rd(8'hE4, "R2"); rd(8'hE5, "R2");
        for (int i = 0; i < 3; i++) wr(8'hED, 8'(8'h11 * (i + 1)), "R4");
        rd(8'h60, "R4"); rd(8'h61, "R4"); rd(8'h62, "R4");
        rd(8'hE4, "R4");
        // R5 wrap of index and of file address
        wr(8'h1F, 8'hC3, "R5"); wr(8'h00, 8'h3C, "R5");
        wr(8'hE2, 8'hFF, "R5"); wr(8'hE3, 8'hFF, "R5");
        rd(8'hEC, "R5");
        rd(8'hE2, "R5"); rd(8'hE3, "R5");
        wr(8'hE2, 8'hE0, "R5"); wr(8'hE3, 8'h01, "R5");
        rd(8'hEC, "R5");
        wr(8'hE4, 8'hFF, "R5"); wr(8'hE5, 8'hFF, "R5");
        wr(8'hED, 8'h99, "R5");
        rd(8'hE4, "R5"); rd(8'hE5, "R5"); rd(8'h1F, "R5");
        // R6 constants and sink: raw bytes at 0xE8/0xEA/0xEC stay put
        rd(8'hE8, "R6"); rd(8'hEA, "R6");
        wr(8'hE4, 8'hC8, "R6"); wr(8'hE5, 8'h00, "R6");
        wr(8'hED, 8'h5A, "R6");              // raw 0xE8
        wr(8'hE4, 8'hCA, "R6");
        wr(8'hED, 8'hA5, "R6");              // raw 0xEA
        wr(8'hED, 8'h3E, "R6");              // raw 0xEB
        wr(8'hED, 8'h6D, "R6");              // raw 0xEC
        wr(8'hE8, 8'h01, "R6"); wr(8'hEA, 8'h77, "R6"); wr(8'hEC, 8'h88, "R6");
        rd(8'hE8, "R6"); rd(8'hEA, "R6");
        wr(8'hE2, 8'hC8, "R6"); wr(8'hE3, 8'h00, "R6");
        rd(8'hEC, "R6");
        wr(8'hE2, 8'hCA, "R6");
        rd(8'hEC, "R6"); rd(8'hEC, "R6"); rd(8'hEC, "R6");
        // R7 conversion register
        wr(8'hF0, 8'h60, "R7"); rd(8'hF0, "R7"); rd(8'hF0, "R7");
        wr(8'hF0, 8'hF0, "R7"); rd(8'hF0, "R7");
        wr(8'hF0, 8'h0F, "R7"); rd(8'hF0, "R7");
        wr(8'hF0, 8'h35, "R7"); rd(8'hF0, "R7");
        // R8 direct write beats the increment
        wr(8'hE2, 8'h10, "R8"); wr(8'hE3, 8'h00, "R8");
        op(1'b1, 8'hEC, 1'b1, 8'hE2, 8'h03, "R8");
        rd(8'hE2, "R8"); rd(8'hE3, "R8");
        op(1'b1, 8'hEC, 1'b1, 8'hE3, 8'h12, "R8");
        rd(8'hE2, "R8"); rd(8'hE3, "R8");
        rd(8'hEC, "R8"); rd(8'hE2, "R8");
        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R9: actual %0d results missing, expected 0", sb.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule